// File: doc/BRIEF.md
# PCI configuration address translator

This block sits between a host register interface and a conventional PCI configuration fabric. Software first stores a 32-bit selector word in an index region. It then reads or writes through a 4 KiB data window. For each data-window access, the block combines the stored selector with the low offset bits of the access. The result is a standard configuration address carrying bus, device/function and register fields. The block issues one downstream configuration request carrying that address, the byte enables and the write data. For reads it waits for the response and returns the data right-justified to the host.

The selector can be given in three forms, and the block picks the form from bits 31 and 0. With bit 31 set, the value passes through almost unchanged. With bit 0 set, it is treated as an already-encoded type-1 style address. With both bits clear, it is a one-hot device select: the lowest set bit among bits 31..11 gives the device number. Both regions use little-endian byte order. The bridge's own function answers at device 11, function 0, which is select bit 11.

The block also combines per-slot interrupt pins onto four host interrupt lines. It rotates each pin by the slot's device number.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the stored selector is zero, and a 4-byte read of the index region (hostSel=0) returns it.
- R2: Only index-region writes with hostSize code 2 or 3 (4 bytes) update the selector; 1- and 2-byte index writes leave it unchanged.
- R3: When selector bit 31 is set, the downstream address is the selector ORed with data-window offset bits [1:0].
- R4: When bit 31 is clear and bit 0 is set, the downstream address is the selector with bits [2:0] replaced by offset bits [2:0]; offset bits above bit 2 are ignored.
- R5: When bits 31 and 0 are both clear, the downstream address is zero above bit 15. Bits [15:11] hold the position of the lowest set selector bit in [31:11]. Bits [10:8] hold selector bits [10:8], bits [7:3] hold selector bits [7:3], and bits [2:0] hold offset bits [2:0].
- R6: In the mode of R5, if selector bits [31:11] are all zero, the device field [15:11] is 31.
- R7: Bit 31 takes priority over bit 0 when both are set.
- R8: hostSize code 0 (1 byte) gives enables 1<<off[1:0]. Code 1 (2 bytes) gives 4'b0011<<(2*off[1]). Codes 2 and 3 (4 bytes) give 4'b1111. Write data is shifted up by the same byte lane.
- R9: A downstream request holds cfgValid, cfgAddr, cfgBe and cfgWdata until cfgReady. A read's hostDone comes only after cfgRvalid, and a write's hostDone comes after acceptance.
- R10: Read data is shifted down by the lane offset and masked to the access size before it is returned on hostRdata.
- R11: Input pin n of slot s (slotIrq bit 4*s+n, device SLOT_BASE+s) drives hostIrq[(n+SLOT_BASE+s) mod 4]. Each output is the OR of its sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request, held until hostDone |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSel | input | 1 | 0 = index region, 1 = data window |
| hostOffset | input | 12 | Byte offset inside the region |
| hostSize | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| hostWdata | input | 32 | Right-justified write data |
| hostRdata | output | 32 | Right-justified read data, valid with hostDone |
| hostDone | output | 1 | One-cycle completion pulse |
| cfgValid | output | 1 | Downstream request valid |
| cfgReady | input | 1 | Downstream request accepted |
| cfgWrite | output | 1 | Downstream request is a write |
| cfgAddr | output | 32 | Translated configuration address |
| cfgBe | output | 4 | Downstream byte enables |
| cfgWdata | output | 32 | Lane-aligned write data |
| cfgRvalid | input | 1 | Downstream read data valid |
| cfgRdata | input | 32 | Downstream read data |
| slotIrq | input | 32 | Interrupt pins, four per slot |
| hostIrq | output | 4 | Host interrupt lines |

## Verification
The assertions check the downstream handshake on every cycle: a stalled request keeps its address and enables, a valid request always carries at least one enable, the completion is a single pulse, and idle interrupt inputs leave every host line low. The address produced in each translation mode, the lowest-select decode and its no-select fallback, the mode priority, the lane and mask arithmetic, and the rule that narrow index writes are ignored are value questions. Only the bench's directed scenarios can show those, because they compare each translated request against values computed from the selector and offset.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned OFF_W  = 12;

  typedef struct packed {
    logic idxWr;   // load selector from host write data
    logic capIdx;  // load read-return register with selector
    logic capRd;   // load read-return register with downstream data
  } cfgx_strobe_t;

  typedef enum logic [1:0] {
    XL_RAW = 2'd0,
    XL_T1  = 2'd1,
    XL_T0  = 2'd2
  } cfgx_mode_t;
endpackage

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostValid,
  input  logic         hostWrite,
  input  logic         hostSel,
  input  logic [1:0]   hostSize,
  input  logic         cfgReady,
  input  logic         cfgRvalid,
  output logic         cfgValid,
  output logic         cfgWrite,
  output logic         hostDone,
  output cfgx_strobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      S_IDLE: if (hostValid) begin
        if (!hostSel) begin
          strobe.idxWr  = hostWrite && hostSize[1];
          strobe.capIdx = !hostWrite;
          stateD = S_DONE;
        end else begin
          stateD = S_REQ;
        end
      end
      S_REQ: if (cfgReady) stateD = hostWrite ? S_DONE : S_WAIT;
      S_WAIT: if (cfgRvalid) begin
        strobe.capRd = 1'b1;
        stateD = S_DONE;
      end
      S_DONE: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign cfgValid = (stateQ == S_REQ);
  assign cfgWrite = hostWrite;
  assign hostDone = (stateQ == S_DONE);

  // R9: a stalled request stays posted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !cfgReady |=> cfgValid);
  // R9: completion is a single pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);
  // R9: a read awaiting data cannot complete in the next cycle
  p_read_waits_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WAIT) && !cfgRvalid |=> !hostDone);
endmodule

// File: rtl/cfgx_path.sv
module cfgx_path
  import cfgx_pkg::*;
#(
  parameter int unsigned DEV_LSB = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgx_strobe_t       strobe,
  input  logic [OFF_W-1:0]   hostOffset,
  input  logic [1:0]         hostSize,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  cfgRdata,
  output logic [DATA_W-1:0]  cfgAddr,
  output logic [BE_W-1:0]    cfgBe,
  output logic [DATA_W-1:0]  cfgWdata,
  output logic [DATA_W-1:0]  hostRdata
);
  localparam int unsigned DEV_W = 5;

  logic [DATA_W-1:0] idxQ, rdQ;
  logic [DEV_W-1:0]  devNum;
  cfgx_mode_t        mode;
  logic [4:0]        laneShift;
  logic [DATA_W-1:0] sizeMask;

  // mode selection: bit 31 first, then bit 0
  always_comb begin
    if (idxQ[DATA_W-1]) mode = XL_RAW;
    else if (idxQ[0])   mode = XL_T1;
    else                mode = XL_T0;
  end

  // lowest set device-select bit; none set gives all ones
  always_comb begin
    devNum = '1;
    for (int b = DATA_W - 1; b >= int'(DEV_LSB); b--) begin
      if (idxQ[b]) devNum = DEV_W'(b);
    end
  end

  always_comb begin
    unique case (mode)
      XL_RAW:  cfgAddr = idxQ | {{(DATA_W-2){1'b0}}, hostOffset[1:0]};
      XL_T1:   cfgAddr = {idxQ[DATA_W-1:3], hostOffset[2:0]};
      default: cfgAddr = {16'h0000, devNum, idxQ[10:8], idxQ[7:3], hostOffset[2:0]};
    endcase
  end

  // byte lanes
  always_comb begin
    unique case (hostSize)
      2'd0: begin
        cfgBe     = BE_W'(4'b0001 << hostOffset[1:0]);
        laneShift = {hostOffset[1:0], 3'b000};
        sizeMask  = 32'h0000_00FF;
      end
      2'd1: begin
        cfgBe     = hostOffset[1] ? 4'b1100 : 4'b0011;
        laneShift = {hostOffset[1], 4'b0000};
        sizeMask  = 32'h0000_FFFF;
      end
      default: begin
        cfgBe     = 4'b1111;
        laneShift = 5'd0;
        sizeMask  = '1;
      end
    endcase
  end

  assign cfgWdata  = hostWdata << laneShift;
  assign hostRdata = rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      rdQ  <= '0;
    end else begin
      if (strobe.idxWr)  idxQ <= hostWdata;
      if (strobe.capIdx) rdQ  <= idxQ;
      else if (strobe.capRd) rdQ <= (cfgRdata >> laneShift) & sizeMask;
    end
  end
endmodule

// File: rtl/cfgx_irq.sv
module cfgx_irq #(
  parameter int unsigned N_SLOTS   = 8,
  parameter int unsigned SLOT_BASE = 11,
  parameter int unsigned N_LINES   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [N_SLOTS*N_LINES-1:0] slotIrq,
  output logic [N_LINES-1:0]         hostIrq
);
  always_comb begin
    hostIrq = '0;
    for (int s = 0; s < int'(N_SLOTS); s++) begin
      for (int n = 0; n < int'(N_LINES); n++) begin
        hostIrq[(n + s + int'(SLOT_BASE)) % int'(N_LINES)] =
          hostIrq[(n + s + int'(SLOT_BASE)) % int'(N_LINES)] | slotIrq[s*N_LINES + n];
      end
    end
  end

  // R11: quiet inputs leave every host line low
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (slotIrq == '0) |-> (hostIrq == '0));
  // R11: one active pin raises exactly one host line
  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(slotIrq) == 1) |-> ($countones(hostIrq) == 1));
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned DEV_LSB   = 11,
  parameter int unsigned N_SLOTS   = 8,
  parameter int unsigned SLOT_BASE = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostValid,
  input  logic                   hostWrite,
  input  logic                   hostSel,
  input  logic [11:0]            hostOffset,
  input  logic [1:0]             hostSize,
  input  logic [31:0]            hostWdata,
  output logic [31:0]            hostRdata,
  output logic                   hostDone,
  output logic                   cfgValid,
  input  logic                   cfgReady,
  output logic                   cfgWrite,
  output logic [31:0]            cfgAddr,
  output logic [3:0]             cfgBe,
  output logic [31:0]            cfgWdata,
  input  logic                   cfgRvalid,
  input  logic [31:0]            cfgRdata,
  input  logic [N_SLOTS*4-1:0]   slotIrq,
  output logic [3:0]             hostIrq
);
  cfgx_strobe_t strobe;

  cfgx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostSize(hostSize), .cfgReady(cfgReady),
    .cfgRvalid(cfgRvalid), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .hostDone(hostDone), .strobe(strobe)
  );

  cfgx_path #(.DEV_LSB(DEV_LSB)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostOffset(hostOffset),
    .hostSize(hostSize), .hostWdata(hostWdata), .cfgRdata(cfgRdata),
    .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata), .hostRdata(hostRdata)
  );

  cfgx_irq #(.N_SLOTS(N_SLOTS), .SLOT_BASE(SLOT_BASE), .N_LINES(4)) u_irq (
    .clk(clk), .rstN(rstN), .slotIrq(slotIrq), .hostIrq(hostIrq)
  );

  // R9: posted request contents stay put while stalled
  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !cfgReady |=> $stable(cfgAddr) && $stable(cfgBe) && $stable(cfgWdata));
  // R8: every request enables at least one byte
  p_be_present_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (cfgBe != 4'b0000));
endmodule

// File: tb/sim_cfg_addr_xlate.sv
module sim_cfg_addr_xlate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostValid = 0, hostWrite = 0, hostSel = 0;
  logic [11:0] hostOffset = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostDone, cfgValid, cfgWrite;
  logic cfgReady = 0, cfgRvalid = 0;
  logic [31:0] cfgAddr, cfgWdata;
  logic [31:0] cfgRdata = '0;
  logic [3:0]  cfgBe, hostIrq;
  logic [31:0] slotIrq = '0;

  int checks = 0, errors = 0;
  int readyDelay = 0, rdDelay = 0;
  logic [31:0] respData = '0;
  logic [31:0] gotAddr, gotWdata;
  logic [3:0]  gotBe;
  logic        gotWrite;

  always #4 clk = ~clk;

  cfg_addr_xlate u0 (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostOffset(hostOffset), .hostSize(hostSize),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostDone(hostDone),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata),
    .cfgRvalid(cfgRvalid), .cfgRdata(cfgRdata), .slotIrq(slotIrq), .hostIrq(hostIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // downstream target model, acting on falling edges
  initial begin
    int st = 0, cnt = 0;
    forever begin
      @(negedge clk);
      case (st)
        0: begin cfgReady = 0; cfgRvalid = 0; if (cfgValid) begin cnt = 0; st = 1; end end
        1: if (cnt >= readyDelay) begin
             cfgReady = 1; gotAddr = cfgAddr; gotBe = cfgBe;
             gotWdata = cfgWdata; gotWrite = cfgWrite; st = 2;
           end else cnt++;
        2: begin cfgReady = 0; cnt = 0; st = gotWrite ? 0 : 3; end
        3: if (cnt >= rdDelay) begin cfgRvalid = 1; cfgRdata = respData; st = 4; end
           else cnt++;
        default: begin cfgRvalid = 0; st = 0; end
      endcase
    end
  end

  task automatic access(input logic sel, input logic wr, input logic [1:0] sz,
                        input logic [11:0] off, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    hostSel = sel; hostWrite = wr; hostSize = sz; hostOffset = off;
    hostWdata = wd; hostValid = 1;
    do @(negedge clk); while (!hostDone);
    rd = hostRdata;
    hostValid = 0;
  endtask

  task automatic setIndex(input logic [31:0] v);
    logic [31:0] d;
    access(0, 1, 2'd2, 12'h000, v, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    access(0, 0, 2'd2, 12'h000, 0, d);
    chk("R1 reset selector", d, 32'h0);
  endtask

  task automatic t_narrow_index();
    logic [31:0] d;
    setIndex(32'h1234_5678);
    access(0, 0, 2'd2, 12'h000, 0, d);
    chk("R2 full write", d, 32'h1234_5678);
    access(0, 1, 2'd0, 12'h000, 32'hFFFF_FFFF, d);
    access(0, 1, 2'd1, 12'h000, 32'hFFFF_FFFF, d);
    access(0, 0, 2'd2, 12'h000, 0, d);
    chk("R2 narrow ignored", d, 32'h1234_5678);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    setIndex(32'h8000_1234);
    respData = 32'hAABB_CCDD; readyDelay = 3; rdDelay = 2;
    access(1, 0, 2'd0, 12'h003, 0, d);
    chk("R3 addr", gotAddr, 32'h8000_1237);
    chk("R8 be byte3", {28'h0, gotBe}, 32'h8);
    chk("R10 byte read", d, 32'h0000_00AA);
    chk("R9 read kind", {31'h0, gotWrite}, 32'h0);
  endtask

  task automatic t_type1();
    logic [31:0] d;
    setIndex(32'h0000_5A0D);
    readyDelay = 2;
    access(1, 1, 2'd1, 12'hFF6, 32'h0000_1234, d);
    chk("R4 addr", gotAddr, 32'h0000_5A0E);
    chk("R8 be half", {28'h0, gotBe}, 32'hC);
    chk("R8 wdata lane", gotWdata, 32'h1234_0000);
    chk("R9 write kind", {31'h0, gotWrite}, 32'h1);
  endtask

  task automatic t_type0();
    logic [31:0] d;
    setIndex(32'h0010_2544);
    respData = 32'h1122_3344; readyDelay = 0; rdDelay = 5;
    access(1, 0, 2'd2, 12'h004, 0, d);
    chk("R5 addr lowest select", gotAddr, 32'h0000_6D44);
    chk("R8 be word", {28'h0, gotBe}, 32'hF);
    chk("R10 word read", d, 32'h1122_3344);
    setIndex(32'h0000_0800);
    access(1, 0, 2'd2, 12'h000, 0, d);
    chk("R5 bridge device 11", gotAddr, 32'h0000_5800);
  endtask

  task automatic t_nosel();
    logic [31:0] d;
    setIndex(32'h0000_0310);
    respData = 32'hCAFE_0000; rdDelay = 0;
    access(1, 0, 2'd1, 12'h002, 0, d);
    chk("R6 device 31", gotAddr, 32'h0000_FB12);
    chk("R10 half read", d, 32'h0000_CAFE);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    setIndex(32'h8000_0001);
    access(1, 1, 2'd0, 12'h002, 32'h0000_005A, d);
    chk("R7 bit31 wins", gotAddr, 32'h8000_0003);
    chk("R8 byte2 lane", gotWdata, 32'h005A_0000);
  endtask

  task automatic t_irq();
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        slotIrq = 32'h1 << (s*4 + n);
        #1;
        chk("R11 swizzle", {28'h0, hostIrq}, 32'h1 << ((n + 11 + s) % 4));
      end
    end
    @(negedge clk);
    slotIrq = 32'h0000_0011; // slot0 pin0 -> 3, slot1 pin0 -> 0
    #1;
    chk("R11 or combine", {28'h0, hostIrq}, 32'h9);
    slotIrq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_narrow_index();
    t_raw();
    t_type1();
    t_type0();
    t_nosel();
    t_priority();
    t_irq();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule